// File: doc/BRIEF.md
# Two-Bank SDRAM Controller

This block connects a single-word host request port to a 16-bit synchronous DRAM that has two banks, an 11-bit row address and an 8-bit column address. The row and column share one address bus. After reset it raises the clock enable and waits for a power-up interval, issuing only NOPs. It then precharges both banks, issues two refreshes and writes the mode register. Only after that does it accept host traffic.

Each host access is one 16-bit word and follows a closed-page policy. The controller issues an activate, then one read or write with auto-precharge. It then waits until the bank is free again. A write masks bytes through the two data-mask pins. A read returns its word on a one-cycle response strobe once the programmed CAS latency has passed.

A refresh scheduler raises a request at a fixed interval. The default interval matches 2048 rows per 32 ms at a 200 MHz clock. A pending refresh is served before the next host request.

Top module: `sdram_ctrl2b`

## Requirements
- R1: After reset release the clock enable goes high and only NOPs are issued for at least INIT_CYCLES clocks. Then, in order, come a precharge with A10 high, two refreshes and a mode-register load. `req_ready` stays low until the load has been issued, and the clock enable is high at least one cycle before the first command.
- R2: The mode word on A10..A0 sets burst length 1 (A2..A0 = 000), sequential order (A3 = 0), CAS latency CAS_LAT (A6..A4), single-word writes (A9 = 1) and zeros elsewhere, with BA = 0.
- R3: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000.
- R4: The host address maps as bit 19 = bank, bits 18..8 = row, bits 7..0 = column. An activate drives the row on A10..A0 and the bank on BA. The column command drives the column on A7..A0, zeros on A9..A8 and a 1 on A10, so the bank auto-precharges.
- R5: Commands keep these spacings: activate to column at least T_RCD; activate to activate at least T_RC; refresh to any command at least T_RC; precharge to any command at least T_RP; mode load to any command at least T_MRD.
- R6: During a write command the controller drives the write data on DQ, with DQM = ~`req_be` (bit 0 = lower byte). It leaves DQ at high impedance on every other cycle. Masked bytes keep their old contents.
- R7: A read command has DQM = 00. `rsp_valid` pulses for one cycle, CAS_LAT+1 clocks after the read command appears on the pins, and carries the word the memory drove on DQ.
- R8: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, all spacings are met and no refresh is pending, so it is low in the cycle after an acceptance.
- R9: One refresh is issued per REF_INTERVAL clocks on average. A steady stream of host requests cannot hold refreshes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | 16 | Read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_a | output | 11 | Multiplexed row/column address, A10 is the precharge flag |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq | inout | 16 | Bidirectional data bus |

## Verification
On every cycle the assertions check the following: the activate-to-column and refresh-to-command spacings, the auto-precharge flag on column commands, the clock enable ahead of any command, and the read response arriving exactly CAS_LAT+1 cycles after a read. They also check that the data bus is driven only during a write and that ready never appears before the mode load or in the cycle after an acceptance. Only the bench scenarios can show the rest. These are the exact power-up order and mode word, the address split, byte-masked writes read back through a memory model, the average refresh rate over a long idle window, and refreshes continuing under a continuous request stream.

// File: rtl/sdc_pkg.sv
// Shared types and constants for the two-bank SDRAM controller.
// Assumes a 16-bit part with 11 row bits, 8 column bits and one bank bit.
package sdc_pkg;
    localparam int SD_ROW_W  = 11;
    localparam int SD_COL_W  = 8;
    localparam int SD_DATA_W = 16;
    localparam int SD_BE_W   = SD_DATA_W / 8;
    localparam int SD_ADDR_W = 1 + SD_ROW_W + SD_COL_W;

    // Pin encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_INIT_PRE_WAIT,
        ST_INIT_REF2,
        ST_INIT_MODE,
        ST_IDLE,
        ST_COLUMN
    } ctl_state_e;

    // Request fields held between activate and column command
    typedef struct packed {
        logic                 write;
        logic                 bank;
        logic [SD_COL_W-1:0]  col;
        logic [SD_DATA_W-1:0] wdata;
        logic [SD_BE_W-1:0]   be;
    } held_req_t;

    // Mode word: burst 1, sequential, given CAS latency, single-word writes
    function automatic logic [SD_ROW_W-1:0] mode_word(input int cas);
        return {1'b0, 1'b1, 2'b00, 3'(cas), 1'b0, 3'b000};
    endfunction
endpackage

// File: rtl/sdc_cmd_timer.sv
// Down-counting spacing timer. Loaded with (gap - 1) when a command is
// issued; expired is high once the gap has elapsed. Reset value sets the
// power-up wait. Assumes load values fit in W bits.
module sdc_cmd_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down to zero, reload on command issue
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= W'(RST_VAL);
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdc_refresh_sched.sv
// Periodic refresh request generator. While enabled it raises pending
// every INTERVAL clocks; pending holds until acknowledged. A tick that
// coincides with an acknowledge keeps pending set.
module sdc_refresh_sched #(
    parameter int INTERVAL = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = enable && (cnt == CW'(INTERVAL - 1));

    // Interval counter
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= '0;
        else if (enable) cnt <= cnt + 1'b1;
    end

    // Sticky request flag
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= tick | (pending & ~ack);
    end
endmodule

// File: rtl/sdc_read_capture.sv
// Tracks issued reads through a CAS_LAT+1 stage pipe and captures the
// data bus when a read reaches the end. Assumes the issue strobe is
// registered on the same edge as the read command pins.
module sdc_read_capture #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CAS_LAT:0] pipe;

    // First stage marks a read leaving the controller
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= issue;
    end

    for (genvar i = 1; i <= CAS_LAT; i++) begin : g_stage
        // Delay stage i of the latency pipe
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= 1'b0;
            else        pipe[i] <= pipe[i-1];
        end
    end

    // Capture the bus when the read has aged out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= pipe[CAS_LAT];
            if (pipe[CAS_LAT]) rsp_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_ctrl2b.sv
// Two-bank SDRAM controller: power-up sequence, mode programming, refresh
// scheduling and single-word closed-page accesses with auto-precharge.
// Assumes INIT_CYCLES is the largest timing value and CAS_LAT is 2 or 3.
module sdram_ctrl2b
    import sdc_pkg::*;
#(
    parameter int INIT_CYCLES  = 40000,
    parameter int REF_INTERVAL = 3120,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RC         = 14,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2,
    parameter int CAS_LAT      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [SD_ADDR_W-1:0] req_addr,
    input  logic [SD_DATA_W-1:0] req_wdata,
    input  logic [SD_BE_W-1:0]   req_be,
    output logic                 rsp_valid,
    output logic [SD_DATA_W-1:0] rsp_rdata,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic                 sd_ba,
    output logic [SD_ROW_W-1:0]  sd_a,
    output logic [SD_BE_W-1:0]   sd_dqm,
    inout  wire  [SD_DATA_W-1:0] sd_dq
);
    localparam int POST_DATA = ((T_WR > CAS_LAT) ? T_WR : CAS_LAT) + T_RP;
    localparam int POST_RC   = T_RC - T_RCD;
    localparam int T_POST    = (POST_DATA > POST_RC) ? POST_DATA : POST_RC;
    localparam int TMR_W     = $clog2(INIT_CYCLES + T_RC + T_POST + 1);

    ctl_state_e             state, nxt_state;
    sd_cmd_e                cmd_q, nxt_cmd;
    logic [SD_ROW_W-1:0]    a_q, nxt_a;
    logic                   ba_q, nxt_ba;
    logic [SD_BE_W-1:0]     dqm_q, nxt_dqm;
    logic                   dq_oe_q, nxt_oe;
    logic [SD_DATA_W-1:0]   dq_out_q;
    logic                   cke_q;
    held_req_t              held;
    logic                   tmr_load, tmr_expired;
    logic [TMR_W-1:0]       tmr_val;
    logic                   ref_pending, ref_ack, rd_issue, accept;

    sdc_cmd_timer #(.W(TMR_W), .RST_VAL(INIT_CYCLES - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_expired)
    );

    sdc_refresh_sched #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk(clk), .rst_n(rst_n),
        .enable(state inside {ST_IDLE, ST_COLUMN}),
        .ack(ref_ack), .pending(ref_pending)
    );

    sdc_read_capture #(.CAS_LAT(CAS_LAT), .DATA_W(SD_DATA_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq),
        .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
    );

    // Host handshake: ready only when idle, timed out and no refresh due
    assign req_ready = (state == ST_IDLE) && tmr_expired && !ref_pending;
    assign accept    = req_valid && req_ready;

    // Next command, address, timer load and state
    always_comb begin
        nxt_state = state;
        nxt_cmd   = CMD_NOP;
        nxt_a     = '0;
        nxt_ba    = 1'b0;
        nxt_dqm   = '0;
        nxt_oe    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ref_ack   = 1'b0;
        rd_issue  = 1'b0;
        case (state)
            ST_POWERUP: if (tmr_expired) begin
                nxt_cmd   = CMD_PRE;
                nxt_a[10] = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(T_RP - 1);
                nxt_state = ST_INIT_PRE_WAIT;
            end
            ST_INIT_PRE_WAIT: if (tmr_expired) begin
                nxt_cmd   = CMD_REF;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(T_RC - 1);
                nxt_state = ST_INIT_REF2;
            end
            ST_INIT_REF2: if (tmr_expired) begin
                nxt_cmd   = CMD_REF;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(T_RC - 1);
                nxt_state = ST_INIT_MODE;
            end
            ST_INIT_MODE: if (tmr_expired) begin
                nxt_cmd   = CMD_MODE;
                nxt_a     = mode_word(CAS_LAT);
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(T_MRD - 1);
                nxt_state = ST_IDLE;
            end
            ST_IDLE: if (tmr_expired) begin
                if (ref_pending) begin
                    nxt_cmd  = CMD_REF;
                    ref_ack  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RC - 1);
                end else if (req_valid) begin
                    nxt_cmd   = CMD_ACT;
                    nxt_ba    = req_addr[SD_ADDR_W-1];
                    nxt_a     = req_addr[SD_COL_W +: SD_ROW_W];
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(T_RCD - 1);
                    nxt_state = ST_COLUMN;
                end
            end
            ST_COLUMN: if (tmr_expired) begin
                nxt_cmd   = held.write ? CMD_WRITE : CMD_READ;
                nxt_ba    = held.bank;
                nxt_a     = {1'b1, 2'b00, held.col};
                nxt_dqm   = held.write ? ~held.be : '0;
                nxt_oe    = held.write;
                rd_issue  = !held.write;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(T_POST - 1);
                nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_POWERUP;
        endcase
    end

    // Register state and all memory-side pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_POWERUP;
            cmd_q    <= CMD_NOP;
            a_q      <= '0;
            ba_q     <= 1'b0;
            dqm_q    <= '1;
            dq_oe_q  <= 1'b0;
            dq_out_q <= '0;
            cke_q    <= 1'b0;
        end else begin
            state    <= nxt_state;
            cmd_q    <= nxt_cmd;
            a_q      <= nxt_a;
            ba_q     <= nxt_ba;
            dqm_q    <= nxt_dqm;
            dq_oe_q  <= nxt_oe;
            dq_out_q <= held.wdata;
            cke_q    <= 1'b1;
        end
    end

    // Hold the accepted request until its column command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (accept) begin
            held.write <= req_write;
            held.bank  <= req_addr[SD_ADDR_W-1];
            held.col   <= req_addr[SD_COL_W-1:0];
            held.wdata <= req_wdata;
            held.be    <= req_be;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_cke = cke_q;
    assign sd_ba  = ba_q;
    assign sd_a   = a_q;
    assign sd_dqm = dqm_q;
    assign sd_dq  = dq_oe_q ? dq_out_q : 'z;
endmodule

// File: rtl/sdram_ctrl2b_chk.sv
// Protocol checker for sdram_ctrl2b, attached by bind. Watches the pins
// and the internal data-bus enable; holds spacing counters of its own.
module sdram_ctrl2b_chk #(
    parameter int T_RCD   = 3,
    parameter int T_RC    = 14,
    parameter int CAS_LAT = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       sd_cke,
    input logic [3:0] cmd_pins,
    input logic [2:0] a_hi,
    input logic       dq_oe
);
    logic [7:0] since_act, since_ref;
    logic       mode_seen;
    logic       is_nop, is_act, is_ref, is_rd, is_wr, is_mode;

    assign is_nop  = (cmd_pins == 4'b0111);
    assign is_act  = (cmd_pins == 4'b0011);
    assign is_ref  = (cmd_pins == 4'b0001);
    assign is_rd   = (cmd_pins == 4'b0101);
    assign is_wr   = (cmd_pins == 4'b0100);
    assign is_mode = (cmd_pins == 4'b0000);

    // Cycles since the last activate and refresh, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 8'hFF;
            since_ref <= 8'hFF;
            mode_seen <= 1'b0;
        end else begin
            since_act <= is_act ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
            since_ref <= is_ref ? 8'd1 : (since_ref == 8'hFF ? since_ref : since_ref + 8'd1);
            if (is_mode) mode_seen <= 1'b1;
        end
    end

    AST_READY_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mode_seen || is_mode)); // R1
    AST_CKE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> $past(sd_cke)); // R1
    AST_COL_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (a_hi == 3'b100)); // R4
    AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (since_act >= 8'(T_RCD))); // R5
    AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> (since_ref >= 8'(T_RC))); // R5
    AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> is_wr); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(is_rd, CAS_LAT + 1)); // R7
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
endmodule

bind sdram_ctrl2b sdram_ctrl2b_chk #(
    .T_RCD(T_RCD), .T_RC(T_RC), .CAS_LAT(CAS_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .sd_cke(sd_cke),
    .cmd_pins({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .a_hi(sd_a[10:8]), .dq_oe(dq_oe_q)
);

// File: tb/sdram_ctrl2b_test.sv
`timescale 1ns/1ps
module sdram_ctrl2b_test;
    localparam int INIT_CYC = 50;
    localparam int REF_INT  = 200;
    localparam int TRCD = 2, TRP = 2, TRC = 6, TMRD = 2, TWR = 2, CL = 3;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MODE = 4'b0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
    logic [15:0] rsp_rdata;
    logic [10:0] sd_a;
    logic [1:0]  sd_dqm;
    wire  [15:0] sd_dq;
    logic m_oe = 1'b0;
    logic [15:0] m_dq = '0;
    assign sd_dq = m_oe ? m_dq : 16'hzzzz;

    always #2.5 clk = ~clk;

    sdram_ctrl2b #(.INIT_CYCLES(INIT_CYC), .REF_INTERVAL(REF_INT), .T_RCD(TRCD),
        .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .T_WR(TWR), .CAS_LAT(CL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
        .sd_dqm(sd_dqm), .sd_dq(sd_dq));

    wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    int errors = 0, checks = 0, cyc = 0, rel_cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: samples pins on the rising edge, returns data after CL
    logic [15:0] mem [int];
    logic [10:0] open_row [2];
    int  mcyc = 0, rd_due = 0;
    bit  rd_pend = 1'b0;
    logic [15:0] rd_word = '0;
    always @(posedge clk) begin
        int key;
        m_oe <= 1'b0;
        if (rd_pend && mcyc == rd_due) begin
            m_oe <= 1'b1; m_dq <= rd_word; rd_pend = 1'b0;
        end
        if (rst_n) begin
            if (cmd == C_ACT) open_row[sd_ba] = sd_a;
            key = int'({sd_ba, open_row[sd_ba], sd_a[7:0]});
            if (cmd == C_RD) begin
                rd_word = mem.exists(key) ? mem[key] : 16'h0000;
                rd_due = mcyc + CL - 1; rd_pend = 1'b1;
            end
            if (cmd == C_WR) begin
                logic [15:0] w;
                w = mem.exists(key) ? mem[key] : 16'h0000;
                if (!sd_dqm[0]) w[7:0]  = sd_dq[7:0];
                if (!sd_dqm[1]) w[15:8] = sd_dq[15:8];
                mem[key] = w;
            end
        end
        mcyc++;
        cyc++;
    end

    // Pin monitor, sampled mid-cycle
    logic [3:0]  log_cmd [8];
    int          log_cyc [8];
    logic [10:0] log_a [8];
    logic        log_ba [8];
    int nlog = 0, last_act = -1000, last_ref = -1000, last_pre = -1000, last_mode = -1000;
    int rd_cyc = -1000, cke_cyc = -1, ref_cnt = 0, n_col = 0, n_rsp = 0;
    int t_err = 0, map_err = 0, wr_err = 0, rd_err = 0, lat_err = 0, hiz_err = 0;
    bit exp_valid = 1'b0, exp_bank = 1'b0;
    logic [10:0] exp_row = '0;
    logic [7:0]  exp_col = '0;
    logic [1:0]  exp_be = '0;
    logic [15:0] exp_wdata = '0;
    always @(negedge clk) if (rst_n) begin
        if (sd_cke && cke_cyc < 0) cke_cyc = cyc;
        if (cmd != C_NOP) begin
            if (nlog < 8) begin
                log_cmd[nlog] = cmd; log_cyc[nlog] = cyc;
                log_a[nlog] = sd_a; log_ba[nlog] = sd_ba; nlog++;
            end
            if (cyc - last_ref < TRC)   t_err++;
            if (cyc - last_pre < TRP)   t_err++;
            if (cyc - last_mode < TMRD) t_err++;
        end
        case (cmd)
            C_ACT: begin
                if (cyc - last_act < TRC) t_err++;
                last_act = cyc;
                if (!exp_valid || sd_ba != exp_bank || sd_a != exp_row) map_err++;
            end
            C_RD, C_WR: begin
                n_col++;
                if (cyc - last_act < TRCD) t_err++;
                if (sd_a != {1'b1, 2'b00, exp_col} || sd_ba != exp_bank) map_err++;
                if (cmd == C_WR) begin
                    if (sd_dqm != ~exp_be || sd_dq !== exp_wdata) wr_err++;
                end else begin
                    if (sd_dqm != 2'b00) rd_err++;
                    rd_cyc = cyc;
                end
            end
            C_REF:  begin ref_cnt++; last_ref = cyc; end
            C_PRE:  last_pre = cyc;
            C_MODE: last_mode = cyc;
            default: ;
        endcase
        if (cmd != C_WR && !m_oe && sd_dq !== 16'hzzzz) hiz_err++;
        if (rsp_valid) begin
            n_rsp++;
            if (cyc - rd_cyc != CL + 1) lat_err++;
        end
    end

    // Bench shadow memory for expected read data
    logic [15:0] shadow [int];

    task automatic host_req(input bit wr, input logic [19:0] addr,
                            input logic [15:0] wd, input logic [1:0] be,
                            output logic [15:0] rd);
        int n0;
        n0 = n_col;
        exp_bank = addr[19]; exp_row = addr[18:8]; exp_col = addr[7:0];
        exp_be = be; exp_wdata = wd; exp_valid = 1'b1;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8", "ready low after accept", 32'(req_ready), 0);
        rd = '0;
        if (wr) begin
            while (n_col == n0) @(negedge clk);
            @(negedge clk);
        end else begin
            while (!rsp_valid) @(negedge clk);
            rd = rsp_rdata;
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    // Vectors {write, addr[19:0], data[15:0], be[1:0]}
    localparam int NV = 12;
    localparam logic [38:0] VEC [NV] = '{
        {1'b1, 20'h00000, 16'hA5A5, 2'b11},
        {1'b1, 20'h80000, 16'h1234, 2'b11},
        {1'b1, 20'h7FFFF, 16'hBEEF, 2'b11},
        {1'b0, 20'h00000, 16'h0000, 2'b00},
        {1'b0, 20'h80000, 16'h0000, 2'b00},
        {1'b0, 20'h7FFFF, 16'h0000, 2'b00},
        {1'b1, 20'h00000, 16'h00FF, 2'b01},
        {1'b0, 20'h00000, 16'h0000, 2'b00},
        {1'b1, 20'h80000, 16'hCC00, 2'b10},
        {1'b0, 20'h80000, 16'h0000, 2'b00},
        {1'b1, 20'h12345, 16'h5A5A, 2'b00},
        {1'b0, 20'h12345, 16'h0000, 2'b00}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int n_reads, ready_cyc, r0;
        n_reads = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sd_cke == 1'b0, "R1", "cke in reset", 32'(sd_cke), 0);
        chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R1", "ready/rsp in reset",
            {req_ready, rsp_valid}, 0);
        chk(cmd == C_NOP, "R3", "NOP in reset", 32'(cmd), 32'(C_NOP));
        rst_n = 1'b1; rel_cyc = cyc;
        while (!req_ready) @(negedge clk);
        ready_cyc = cyc;
        // R1/R3: power-up order
        chk(log_cmd[0] == C_PRE && log_a[0][10], "R1", "first cmd precharge-all",
            {log_cmd[0], log_a[0]}, {C_PRE, 11'h400});
        chk(log_cyc[0] - rel_cyc >= INIT_CYC, "R1", "power-up wait",
            32'(log_cyc[0] - rel_cyc), INIT_CYC);
        chk(cke_cyc >= 0 && cke_cyc < log_cyc[0], "R1", "cke before first cmd",
            32'(cke_cyc), 32'(log_cyc[0]));
        chk(log_cmd[1] == C_REF && log_cmd[2] == C_REF, "R3", "two refresh encodings",
            {log_cmd[1], log_cmd[2]}, {C_REF, C_REF});
        chk(log_cmd[3] == C_MODE && ready_cyc > log_cyc[3], "R1", "mode load before ready",
            32'(log_cmd[3]), 32'(C_MODE));
        // R2: mode word
        chk(log_a[3] == {1'b0, 1'b1, 2'b00, 3'(CL), 1'b0, 3'b000} && !log_ba[3], "R2",
            "mode word", {log_ba[3], log_a[3]}, {1'b0, 1'b0, 1'b1, 2'b00, 3'(CL), 4'b0});

        // Vector walk: writes update the shadow, reads compare to it
        for (int i = 0; i < NV; i++) begin
            logic [38:0] v;
            int key;
            v = VEC[i];
            key = int'(v[37:18]);
            host_req(v[38], v[37:18], v[17:2], v[1:0], rd);
            if (v[38]) begin
                shadow[key] = merge(shadow.exists(key) ? shadow[key] : 16'h0,
                                    v[17:2], v[1:0]);
            end else begin
                n_reads++;
                chk(rd == (shadow.exists(key) ? shadow[key] : 16'h0), "R7",
                    $sformatf("read data vec %0d", i), rd,
                    shadow.exists(key) ? shadow[key] : 16'h0);
            end
        end
        // R6: byte-masked writes kept the other byte
        chk(shadow[int'(20'h00000)] == 16'hA5FF, "R6", "lower-byte write merge",
            shadow[int'(20'h00000)], 16'hA5FF);

        // R9: refresh still issued under a continuous request stream
        r0 = ref_cnt;
        for (int i = 0; i < 40; i++) begin
            host_req(1'b0, 20'h80000, 16'h0, 2'b00, rd);
            n_reads++;
        end
        chk(ref_cnt - r0 >= 1, "R9", "refresh under load", 32'(ref_cnt - r0), 1);
        // R9: average refresh rate while idle
        r0 = ref_cnt;
        repeat (10 * REF_INT) @(negedge clk);
        chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R9", "idle refresh count",
            32'(ref_cnt - r0), 10);

        chk(t_err == 0, "R5", "spacing violations", 32'(t_err), 0);
        chk(map_err == 0, "R4", "address mapping", 32'(map_err), 0);
        chk(wr_err == 0, "R6", "write data/mask", 32'(wr_err), 0);
        chk(hiz_err == 0, "R6", "bus high-Z outside writes", 32'(hiz_err), 0);
        chk(rd_err == 0, "R7", "read dqm", 32'(rd_err), 0);
        chk(lat_err == 0, "R7", "read latency", 32'(lat_err), 0);
        chk(n_rsp == n_reads, "R7", "response count", 32'(n_rsp), 32'(n_reads));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule